// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a memory-mapped timer that raises an interrupt at a fixed, programmable interval. A divide-by-16 prescaler on the system clock produces a count tick. A 20-bit current-value counter counts ticks from zero up to a programmed limit and then returns to zero. Each return to zero marks one completed period. A 12-bit elapsed-period counter records how many periods have finished since software last acknowledged. Software can therefore recover ticks it missed while its interrupt handler was delayed.

Software reaches the block through a plain register bus with address, write strobe, write data, read strobe and read data. Read data is registered and appears the cycle after the read strobe. Two read offsets return the same packed word: the elapsed-period count in the upper 12 bits and the current value in the lower 20 bits. Reading one of them acknowledges the timer. Reading the other has no side effects, so it can serve as a free-running time base. The interrupt can be masked without stopping the count. Clearing the enable does not stop the counter at once: it keeps counting until the current value comes back to zero. Software polls for a zero current value to know that the timer has stopped.

Top module: `pit_timer`

## Requirements
- R1: After reset, every register, counter and the prescaler are zero, every mapped read returns 0, and `irq` is low.
- R2: The control register sits at offset 0x00. Its limit field is bits 19:0, the count enable is bit 24 and the interrupt enable is bit 25. It reads back with all other bits as zero.
- R3: While running, the current value advances exactly once per 16 clock cycles. The first advance falls on the 16th rising edge after the edge that wrote the enable.
- R4: The current value counts 0, 1, … up to the limit field, then returns to 0, so one period is limit+1 ticks.
- R5: Each return to zero adds one to the 12-bit elapsed-period count. The count rolls over from 4095 to 0.
- R6: A read of offset 0x08 returns {elapsed count[11:0], current value[19:0]} as they were before the read. The same read clears the elapsed count and the status flag.
- R7: A read of offset 0x0C returns the same packed word and changes neither counter nor the status flag.
- R8: The status flag is bit 0 at offset 0x04 and is set by a completed period. `irq` is high exactly while the status flag and the interrupt enable are both set.
- R9: With the interrupt enable clear and the count enable set, counting continues and the status flag still sets, but `irq` stays low.
- R10: If a period completes in the same cycle as an acknowledging read, the status flag stays set and the elapsed count becomes 1.
- R11: After the count enable is cleared, counting continues until the current value returns to 0 (that return counts as a period), and then the timer holds at 0.
- R12: Writes to offsets 0x04, 0x08 and 0x0C are ignored, and reads of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 32 | Read data, registered, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt |

## Verification
The counting path is exercised with three limits. A limit of 4 checks the edge-exact tick spacing and the wrap point. A limit of 0 makes every tick a wrap, so the elapsed count fills quickly: it reaches 4095, rolls over, and lines an acknowledge up with a wrap on the same edge. A limit of 3, with the enable cleared part-way through a period, tells a drain that stops at zero apart from one that stops at once or never stops. In every case, side-effect-free reads placed between acknowledging reads show whether only the acknowledge clears the elapsed count and the flag. Writes to read-only offsets and reads of unmapped ones are checked against the reset values.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int DATA_W  = 32;
  localparam int VAL_W   = 20;
  localparam int CNT_W   = DATA_W - VAL_W;
  localparam int EN_BIT  = 24;
  localparam int IEN_BIT = 25;
  localparam int PRESCALE = 16;

  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_STATUS = 'h04;
  localparam int OFF_ACK    = 'h08;
  localparam int OFF_PEEK   = 'h0C;

  // bits of the control word that hold state
  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[VAL_W-1:0] = '1;
    m[EN_BIT]    = 1'b1;
    m[IEN_BIT]   = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] phase_q;

  assign tick = run && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (!run)     phase_q <= '0;
    else if (tick)     phase_q <= '0;
    else               phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/pit_interval_ctr.sv
module pit_interval_ctr #(
  parameter int VAL_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [VAL_W-1:0] limit,
  output logic [VAL_W-1:0] value,
  output logic             wrap,
  output logic             busy
);
  logic [VAL_W-1:0] val_q;

  assign wrap  = tick && (val_q == limit);
  assign busy  = (val_q != '0);
  assign value = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     val_q <= '0;
    else if (wrap)  val_q <= '0;
    else if (tick)  val_q <= val_q + 1'b1;
  end
endmodule

// File: rtl/pit_period_ctr.sv
module pit_period_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             ack,
  output logic [CNT_W-1:0] count,
  output logic             flag
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ack)       cnt_q <= wrap ? CNT_W'(1) : '0;
      else if (wrap) cnt_q <= cnt_q + 1'b1;

      if (wrap)      flag_q <= 1'b1;
      else if (ack)  flag_q <= 1'b0;
    end
  end

  assign count = cnt_q;
  assign flag  = flag_q;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam logic [DATA_W-1:0] MASK = ctrl_mask();

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rd_q;
  logic              tick, wrap, busy, run, ack, status;
  logic              cnt_en, int_en;
  logic [VAL_W-1:0]  cur_val;
  logic [CNT_W-1:0]  per_cnt;

  logic sel_ctrl, sel_stat, sel_ack, sel_peek;
  assign sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
  assign sel_stat = (addr == ADDR_W'(OFF_STATUS));
  assign sel_ack  = (addr == ADDR_W'(OFF_ACK));
  assign sel_peek = (addr == ADDR_W'(OFF_PEEK));

  assign cnt_en = ctrl_q[EN_BIT];
  assign int_en = ctrl_q[IEN_BIT];
  assign run    = cnt_en || busy;
  assign ack    = rd_en && sel_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ctrl_q <= '0;
    else if (wr_en && sel_ctrl)   ctrl_q <= wr_data & MASK;
  end

  pit_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  pit_interval_ctr #(.VAL_W(VAL_W)) u_ival (
    .clk(clk), .rst_n(rst_n), .tick(tick), .limit(ctrl_q[VAL_W-1:0]),
    .value(cur_val), .wrap(wrap), .busy(busy)
  );

  pit_period_ctr #(.CNT_W(CNT_W)) u_per (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .ack(ack),
    .count(per_cnt), .flag(status)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_ctrl)                  rd_mux = ctrl_q;
    else if (sel_stat)             rd_mux = DATA_W'(status);
    else if (sel_ack || sel_peek)  rd_mux = {per_cnt, cur_val};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_en)  rd_q <= rd_mux;
  end

  assign rd_data = rd_q;
  assign irq     = status && int_en;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int VAL_W = 20,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wrap,
  input logic             ack,
  input logic             cnt_en,
  input logic             int_en,
  input logic             status,
  input logic             irq,
  input logic [VAL_W-1:0] cur_val,
  input logic [CNT_W-1:0] per_cnt
);
  p_cur_moves_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_val) |-> $past(tick));

  p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cur_val == '0));

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(per_cnt) && !$past(ack)) |-> (per_cnt == $past(per_cnt) + 1'b1));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack) && !$past(wrap)) |-> (per_cnt == '0 && !status));

  p_status_from_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(wrap));

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_en && status));

  p_coincide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack) && $past(wrap)) |-> (per_cnt == CNT_W'(1) && status));

  p_drain_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && cur_val == '0) |=> (cur_val == '0));
endmodule

bind pit_timer pit_timer_chk #(.VAL_W(pit_pkg::VAL_W), .CNT_W(pit_pkg::CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .ack(ack),
  .cnt_en(cnt_en), .int_en(int_en), .status(status), .irq(irq),
  .cur_val(cur_val), .per_cnt(per_cnt)
);

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  localparam logic [31:0] EN  = 32'h0100_0000;
  localparam logic [31:0] IEN = 32'h0200_0000;

  always #2 clk = ~clk;

  pit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge; each bus op spans one rising edge.
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h00, d); check("R1 ctrl", d, 32'h0);
    rd(8'h04, d); check("R1 status", d, 32'h0);
    rd(8'h08, d); check("R1 ack view", d, 32'h0);
    rd(8'h0C, d); check("R1 peek view", d, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R12 status write ignored", d, 32'h0);
    rd(8'h0C, d); check("R12 counter write ignored", d, 32'h0);
    rd(8'h00, d); check("R12 ctrl untouched", d, 32'h0);
    rd(8'h10, d); check("R12 unmapped read", d, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R2 ctrl readback mask", d, 32'h030F_FFFF);
    rd(8'h40, d); check("R12 unmapped read while on", d, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    do_reset();
    wr(8'h00, EN | 32'd4);             // E0
    idle(37);                          // E1..E37
    rd(8'h0C, d); check("R3 two ticks", d, 32'h2);            // E38
    idle(9);                           // E39..E47
    rd(8'h0C, d); check("R3 before third tick", d, 32'h2);    // E48
    rd(8'h0C, d); check("R3 third tick on edge 48", d, 32'h3); // E49
    idle(31);                          // E50..E80
    rd(8'h0C, d); check("R4 wrap after limit+1 ticks", d, 32'h0010_0000); // E81
    rd(8'h04, d); check("R8 status set", d, 32'h1);           // E82
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    rd(8'h0C, d); check("R7 peek keeps count", d, 32'h0010_0000); // E83
    wr(8'h00, EN | IEN | 32'd4);       // E84
    check("R8 irq on unmask", {31'b0, irq}, 32'h1);
    rd(8'h08, d); check("R6 ack returns old word", d, 32'h0010_0000); // E85
    rd(8'h0C, d); check("R6 count cleared", d, 32'h0);        // E86
    rd(8'h04, d); check("R6 status cleared", d, 32'h0);       // E87
    check("R8 irq low after ack", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_coincide();
    logic [31:0] d;
    do_reset();
    wr(8'h00, EN | IEN);               // limit 0, E0
    idle(79);
    rd(8'h0C, d); check("R5 four periods", d, 32'h0040_0000); // E80
    check("R8 irq high", {31'b0, irq}, 32'h1);
    idle(15);                          // E81..E95
    rd(8'h08, d); check("R10 ack read value", d, 32'h0050_0000); // E96, wrap same edge
    rd(8'h0C, d); check("R10 count is one", d, 32'h0010_0000);
    rd(8'h04, d); check("R10 status kept", d, 32'h1);
    check("R10 irq kept", {31'b0, irq}, 32'h1);
    rd(8'h08, d); check("R6 second ack", d, 32'h0010_0000);   // E99
    rd(8'h04, d); check("R6 status clear", d, 32'h0);
    check("R8 irq clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_rollover();
    logic [31:0] d;
    do_reset();
    wr(8'h00, EN);                     // limit 0, E0
    idle(65535);
    rd(8'h0C, d); check("R5 count at 4095", d, 32'hFFF0_0000);
    rd(8'h0C, d); check("R5 count rolls to 0", d, 32'h0);
    rd(8'h04, d); check("R8 status after rollover", d, 32'h1);
  endtask

  task automatic t_drain();
    logic [31:0] d;
    do_reset();
    wr(8'h00, EN | 32'd3);             // E0
    idle(40);                          // value 2 after E40
    wr(8'h00, 32'd3);                  // E41, enable cleared
    idle(8);
    rd(8'h0C, d); check("R11 still counting", d, 32'h3);      // E50
    idle(13);
    rd(8'h0C, d); check("R11 holds before last tick", d, 32'h3); // E64
    rd(8'h0C, d); check("R11 drained to zero", d, 32'h0010_0000); // E65
    idle(100);
    rd(8'h0C, d); check("R11 stopped", d, 32'h0010_0000);
    rd(8'h00, d); check("R2 enable readback clear", d, 32'h3);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    idle(1);
    t_reset_state();
    t_map();
    t_count();
    t_coincide();
    t_drain();
    t_rollover();
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule